// File: doc/BRIEF.md
# Power Switch Failure Qualifier

This block decides, for each port in a bank of power ports, when the external switch transistor of that port has failed. Two comparator flags arrive per port: one says the current-sense node is abnormally high, the other says the gate node is abnormally high. Either flag counts as an abnormal condition. The block times the condition against a 1 µs tick. If the condition stays present without a break past the qualification window, the block declares a failed-switch fault on that port.

A declared fault is sticky. It takes the port out of service by forcing its drive enable low, whatever the host's enable command says. It also selects the reduced gate pulldown current. Only a per-port reset or the global reset clears it. If the condition is still present after a clear, the fault is declared again after a full new window. Each newly declared fault raises one summary interrupt, and that interrupt stays high until the host acknowledges it. Ports are fully independent of one another.

Top module: `fet_fault_qual`

## Requirements
- R1: A port's abnormal condition is the OR of its sense-high flag (`sense_hi[i]`) and its gate-high flag (`gate_hi[i]`). Either flag alone qualifies.
- R2: The fault is declared on the clock edge that samples the 181st tick (`tick_us` high) of an unbroken abnormal condition. After 180 such ticks, `fet_bad[i]` is still 0.
- R3: If the abnormal condition drops for even one clock before the fault is declared, the tick count restarts from zero.
- R4: While `fet_bad[i]` is 1, `drive_en[i]` is 0 even if `port_en[i]` is 1. Otherwise `drive_en[i]` equals `port_en[i]`.
- R5: `weak_pd[i]` is 1 exactly while the port's fault is latched.
- R6: A declared fault stays latched after the condition goes away. Only `port_rst[i]` (per-port, active high) or `rst_n` (global, active low) clears it.
- R7: After a port reset with the condition still present, the fault comes back after another 181 ticks, and not sooner.
- R8: The condition, fault or reset on one port changes no output bit of any other port.
- R9: Toggling `port_en` while both comparator flags are low never produces a fault, however many ticks pass.
- R10: `irq` rises on the edge where any port's fault is newly declared. It then stays high until `irq_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, clears everything |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| sense_hi | input | NPORTS | Per-port sense-node-high comparator flag |
| gate_hi | input | NPORTS | Per-port gate-node-high comparator flag |
| port_en | input | NPORTS | Host enable command per port |
| port_rst | input | NPORTS | Per-port reset pulse, clears fault and count |
| irq_clr | input | 1 | Host acknowledge of the summary interrupt |
| drive_en | output | NPORTS | Port drive permitted |
| weak_pd | output | NPORTS | Select reduced gate pulldown current |
| fet_bad | output | NPORTS | Sticky failed-switch status |
| irq | output | 1 | Summary interrupt for newly declared faults |

## Verification
The assertions assume that `tick_us` is a single-cycle pulse and that the comparator flags are synchronous and free of glitches. They also assume that a port reset is a pulse the host issues on purpose, not one that is held during qualification. The stimulus drives every input on the falling clock edge and spaces ticks one idle cycle apart, so a dropout of the condition always falls between counted ticks. Port resets and interrupt acknowledges are applied as single-cycle pulses.

// File: rtl/fetq_pkg.sv
package fetq_pkg;
  // abnormal condition of one port
  function automatic logic abnormal(input logic sense, input logic gate);
    return sense | gate;
  endfunction

  // the tick that would take the count past the limit declares the fault
  function automatic logic declare_now(input int unsigned cnt, input int unsigned limit,
                                       input logic tick, input logic abn);
    return tick && abn && (cnt == limit);
  endfunction

  // next value of a qualification count
  function automatic int unsigned count_next(input int unsigned cnt, input int unsigned limit,
                                             input logic tick, input logic abn, input logic clr);
    if (clr || !abn) return 0;
    if (tick && cnt < limit) return cnt + 1;
    return cnt;
  endfunction
endpackage

// File: rtl/fetq_qual_timer.sv
module fetq_qual_timer #(
  parameter int LIMIT = 180,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          abn,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  import fetq_pkg::*;

  int unsigned nxt;

  always_comb begin
    nxt = count_next(int'(cnt), LIMIT, tick, abn, clr);
    hit = declare_now(int'(cnt), LIMIT, tick, abn) && !clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt[CW-1:0];
  end
endmodule

// File: rtl/fetq_fault_latch.sv
module fetq_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  input  logic en_cmd,
  output logic bad,
  output logic drive_en,
  output logic weak_pd,
  output logic new_fault
);
  always_ff @(posedge clk) begin
    if (!rst_n)   bad <= 1'b0;
    else if (clr) bad <= 1'b0;
    else if (hit) bad <= 1'b1;
  end

  always_comb begin
    new_fault = hit && !bad && !clr;
    drive_en  = en_cmd && !bad;
    weak_pd   = bad;
  end
endmodule

// File: rtl/fetq_irq.sv
module fetq_irq #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] new_vec,
  input  logic         ack,
  output logic         irq
);
  logic any_new;
  assign any_new = |new_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (any_new) irq <= 1'b1;
    else if (ack)     irq <= 1'b0;
  end
endmodule

// File: rtl/fet_fault_qual.sv
module fet_fault_qual #(
  parameter int NPORTS     = 12,
  parameter int QUAL_TICKS = 180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [NPORTS-1:0] sense_hi,
  input  logic [NPORTS-1:0] gate_hi,
  input  logic [NPORTS-1:0] port_en,
  input  logic [NPORTS-1:0] port_rst,
  input  logic              irq_clr,
  output logic [NPORTS-1:0] drive_en,
  output logic [NPORTS-1:0] weak_pd,
  output logic [NPORTS-1:0] fet_bad,
  output logic              irq
);
  import fetq_pkg::*;

  localparam int CW = $clog2(QUAL_TICKS + 1);

  // named internal events, observed by the checker
  logic [NPORTS-1:0]    abn_vec;
  logic [NPORTS-1:0]    hit_vec;
  logic [NPORTS-1:0]    new_vec;
  logic [NPORTS*CW-1:0] cnt_flat;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [CW-1:0] cnt_i;

    assign abn_vec[i] = abnormal(sense_hi[i], gate_hi[i]);
    assign cnt_flat[i*CW +: CW] = cnt_i;

    fetq_qual_timer #(.LIMIT(QUAL_TICKS)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (port_rst[i]),
      .tick (tick_us),
      .abn  (abn_vec[i]),
      .cnt  (cnt_i),
      .hit  (hit_vec[i])
    );

    fetq_fault_latch u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (port_rst[i]),
      .hit      (hit_vec[i]),
      .en_cmd   (port_en[i]),
      .bad      (fet_bad[i]),
      .drive_en (drive_en[i]),
      .weak_pd  (weak_pd[i]),
      .new_fault(new_vec[i])
    );
  end

  fetq_irq #(.N(NPORTS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .new_vec(new_vec),
    .ack    (irq_clr),
    .irq    (irq)
  );
endmodule

// File: rtl/fetq_checker.sv
module fetq_checker #(
  parameter int NPORTS     = 12,
  parameter int QUAL_TICKS = 180,
  localparam int CW = $clog2(QUAL_TICKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic [NPORTS-1:0] abn_vec,
  input logic [NPORTS-1:0] hit_vec,
  input logic [NPORTS-1:0] port_en,
  input logic [NPORTS-1:0] port_rst,
  input logic [NPORTS-1:0] drive_en,
  input logic [NPORTS-1:0] weak_pd,
  input logic [NPORTS-1:0] fet_bad,
  input logic [NPORTS*CW-1:0] cnt_flat,
  input logic              irq
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    logic [CW-1:0] c;
    assign c = cnt_flat[i*CW +: CW];

    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fet_bad[i]) |-> $past(hit_vec[i] && tick_us)); // R2
    AST_NO_FAULT_WITHOUT_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (!abn_vec[i] && !fet_bad[i]) |=> !fet_bad[i]); // R9
    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !abn_vec[i] |=> (c == '0)); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      c <= CW'(QUAL_TICKS)); // R2
    AST_DRIVE_OFF_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      fet_bad[i] |-> !drive_en[i]); // R4
    AST_WEAK_PD_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      weak_pd[i] == fet_bad[i]); // R5
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fet_bad[i] && !port_rst[i]) |=> fet_bad[i]); // R6
    AST_PORT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst[i] |=> (!fet_bad[i] && c == '0)); // R7
    AST_IRQ_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fet_bad[i]) |-> irq); // R10
  end
endmodule

bind fet_fault_qual fetq_checker #(.NPORTS(NPORTS), .QUAL_TICKS(QUAL_TICKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_us (tick_us),
  .abn_vec (abn_vec),
  .hit_vec (hit_vec),
  .port_en (port_en),
  .port_rst(port_rst),
  .drive_en(drive_en),
  .weak_pd (weak_pd),
  .fet_bad (fet_bad),
  .cnt_flat(cnt_flat),
  .irq     (irq)
);

// File: tb/sim_fet_fault_qual.sv
`timescale 1ns/1ps
module sim_fet_fault_qual;
  localparam int N   = 12;
  localparam int LIM = 180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic [N-1:0] sense_hi = '0, gate_hi = '0, port_en = '0, port_rst = '0;
  logic irq_clr = 1'b0;
  logic [N-1:0] drive_en, weak_pd, fet_bad;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fet_fault_qual #(.NPORTS(N), .QUAL_TICKS(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .sense_hi(sense_hi), .gate_hi(gate_hi), .port_en(port_en),
    .port_rst(port_rst), .irq_clr(irq_clr),
    .drive_en(drive_en), .weak_pd(weak_pd), .fet_bad(fet_bad), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // n ticks, one idle cycle between; ends on a negedge with outputs settled
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
    end
  endtask

  task automatic pulse_port_rst(input logic [N-1:0] m);
    @(negedge clk) port_rst = m;
    @(negedge clk) port_rst = '0;
  endtask

  task automatic ack_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // expected outputs from a bench-side fault vector
  task automatic chk_outs(input string req, input logic [N-1:0] bad);
    chk({req, " fet_bad"},  32'(fet_bad),  32'(bad));
    chk({req, " weak_pd"},  32'(weak_pd),  32'(bad));                 // R5
    chk({req, " drive_en"}, 32'(drive_en), 32'(port_en & ~bad));      // R4
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    port_en = '1;
    @(negedge clk);
    chk_outs("reset", '0);
    chk("reset irq", 32'(irq), 0);

    // R2: exactly the limit is not enough, one more tick declares
    sense_hi[0] = 1'b1;
    ticks(LIM);
    chk_outs("R2 at 180 ticks", '0);
    ticks(1);
    chk_outs("R2 at 181 ticks", 12'h001);
    chk("R10 irq set", 32'(irq), 1);

    // R6: sticky after condition clears, irq held until ack
    sense_hi[0] = 1'b0;
    ticks(20);
    chk_outs("R6 sticky", 12'h001);
    chk("R10 irq held", 32'(irq), 1);
    ack_irq();
    chk("R10 irq cleared", 32'(irq), 0);

    // R7: port reset with condition present -> refault after full window
    sense_hi[0] = 1'b1;
    pulse_port_rst(12'h001);
    chk_outs("R6 port reset clears", '0);
    ticks(LIM);
    chk_outs("R7 no early refault", '0);
    ticks(1);
    chk_outs("R7 refault", 12'h001);
    sense_hi[0] = 1'b0;
    pulse_port_rst(12'h001);
    ack_irq();

    // R3: dropout restarts the count
    gate_hi[5] = 1'b1;
    ticks(150);
    @(negedge clk) gate_hi[5] = 1'b0;
    @(negedge clk) gate_hi[5] = 1'b1;
    ticks(150);
    chk_outs("R3 restart after dropout", '0);
    ticks(31);
    chk_outs("R3 181 after restart", 12'h020);
    gate_hi[5] = 1'b0;
    pulse_port_rst(12'h020);
    ack_irq();

    // R9: enable toggling with flags low never faults
    for (int k = 0; k < 400; k++) begin
      @(negedge clk) port_en = port_en ^ 12'(k * 7 + 1);
      tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
    end
    chk_outs("R9 enable toggling", '0);
    chk("R9 no irq", 32'(irq), 0);
    port_en = 12'h5A5;

    // R1/R8: sweep every port, alternating which flag is used
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] m;
      m = 12'(1) << p;
      if (p % 2 == 0) sense_hi = m; else gate_hi = m;
      ticks(LIM + 1);
      chk_outs($sformatf("R1 R8 port %0d", p), m);
      chk($sformatf("R10 port %0d irq", p), 32'(irq), 1);
      sense_hi = '0; gate_hi = '0;
      ack_irq();
      pulse_port_rst(m);
      chk_outs($sformatf("R8 port %0d cleared", p), '0);
    end

    // R8: faulting one port while another is mid-count
    sense_hi[2] = 1'b1;
    ticks(100);
    gate_hi[9] = 1'b1;
    ticks(81);
    chk_outs("R8 port2 only", 12'h004);
    pulse_port_rst(12'h004);
    chk_outs("R8 reset port2 keeps 9 count", '0);
    ticks(100);
    chk_outs("R8 port9 declared", 12'h200);

    // R6: global reset clears everything
    @(negedge clk) rst_n = 1'b0;
    sense_hi = '0; gate_hi = '0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R6 global reset", '0);
    chk("R6 global reset irq", 32'(irq), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule